// File: doc/BRIEF.md
# Encoded-Operation Integer ALU

This block is the execute-stage integer unit of a small load/store processor. It takes two operands, a separate shift amount taken from the instruction, and a 4-bit operation code. From these it produces a result word and a flag that says whether that result is zero. The unit covers:

- bitwise logic;
- wrapping addition and subtraction;
- placing a 16-bit immediate in the upper half of the word;
- signed and unsigned set-on-less-than;
- left, logical right and arithmetic right shifts, each available with the amount taken from the instruction field or from operand A.

The decoder upstream chooses between register and immediate operands and does any sign extension before the operands reach this unit. One cycle after the inputs are presented, the result and flag appear on output registers that have a synchronous active-high reset. The operand width is a parameter. The shift-amount width and the half-word size are derived from it.

Top module: `alu_core`

## Requirements
- R1: Codes 0 to 3 (binary 0000, 0001, 0010, 0011) give A AND B, A OR B, A XOR B and NOT (A OR B) respectively.
- R2: Code 4 gives A + B modulo 2^32, and nothing reports overflow.
- R3: Code 5 gives A − B modulo 2^32, so equal operands produce zero.
- R4: Code 6 gives B[15:0] in result bits 31:16, with bits 15:0 cleared.
- R5: Code 7 gives 1 in bit 0 when A < B as two's-complement numbers, and 0 otherwise; bits 31:1 are always zero.
- R6: Code 8 is the same comparison as R5, with A and B treated as unsigned.
- R7: Codes 9, 10 and 11 shift B left logically, right logically and right arithmetically by the 5-bit shift-amount input.
- R8: Codes 12, 13 and 14 perform the same three shifts of B, by the amount in A[4:0]; the shift-amount input has no effect.
- R9: Code 15 gives an all-zero result.
- R10: The zero output is 1 exactly when the registered result is all zeros, whatever the code.
- R11: While reset is high at a rising edge, result becomes 0 and zero becomes 1.
- R12: Result and zero change only at a rising clock edge, and they reflect the inputs present at that edge.
- R13: A shift by 0 returns B unchanged. An arithmetic right shift by 31 of a value with bit 31 set gives all ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_code | input | 4 | Operation select |
| opnd_a | input | 32 | Operand A; its low 5 bits give the variable shift amount |
| opnd_b | input | 32 | Operand B; the value that is shifted or placed |
| shamt | input | 5 | Shift amount from the instruction |
| result | output | 32 | Registered result |
| zero | output | 1 | Registered flag, set when the result is zero |

## Verification
Both outputs are due on the first rising edge after a stimulus is applied, with no further delay for any code. The bench therefore changes inputs 1 ns after an edge and compares 1 ns after the next edge, against a model that uses the language's own operators. One check also samples the outputs just after new inputs arrive, before the edge, to confirm they still hold the previous result. The sweep crosses every code with boundary operands (0, 1, all ones, the sign bit alone, the largest positive value) and shift amounts 0, 1, 16 and 31, then adds random vectors.

// File: rtl/alu_pkg.sv
package alu_pkg;

  typedef enum logic [3:0] {
    OP_AND  = 4'd0,
    OP_OR   = 4'd1,
    OP_XOR  = 4'd2,
    OP_NOR  = 4'd3,
    OP_ADD  = 4'd4,
    OP_SUB  = 4'd5,
    OP_UPH  = 4'd6,
    OP_LTS  = 4'd7,
    OP_LTU  = 4'd8,
    OP_SLI  = 4'd9,
    OP_SRI  = 4'd10,
    OP_SAI  = 4'd11,
    OP_SLV  = 4'd12,
    OP_SRV  = 4'd13,
    OP_SAV  = 4'd14,
    OP_NONE = 4'd15
  } alu_op_e;

  typedef enum logic [1:0] {
    SH_LEFT  = 2'd0,
    SH_RLOG  = 2'd1,
    SH_RARI  = 2'd2
  } shift_mode_e;

endpackage

// File: rtl/alu_logic_unit.sv
module alu_logic_unit
  import alu_pkg::*;
#(
  parameter int W = 32
) (
  input  alu_op_e        op,
  input  logic [W-1:0]   a,
  input  logic [W-1:0]   b,
  output logic [W-1:0]   y
);
  localparam int HALF = W / 2;

  always_comb begin
    case (op)
      OP_AND:  y = a & b;
      OP_OR:   y = a | b;
      OP_XOR:  y = a ^ b;
      OP_NOR:  y = ~(a | b);
      OP_UPH:  y = {b[HALF-1:0], {(W-HALF){1'b0}}};
      default: y = '0;
    endcase
  end
endmodule

// File: rtl/alu_arith_unit.sv
module alu_arith_unit
  import alu_pkg::*;
#(
  parameter int W = 32
) (
  input  alu_op_e        op,
  input  logic [W-1:0]   a,
  input  logic [W-1:0]   b,
  output logic [W-1:0]   sum,
  output logic           lt_signed,
  output logic           lt_unsigned
);
  logic          subtract;
  logic [W-1:0]  b_eff;
  logic [W:0]    full;

  // One adder serves add, subtract and both comparisons.
  assign subtract = (op != OP_ADD);
  assign b_eff    = subtract ? ~b : b;
  assign full     = {1'b0, a} + {1'b0, b_eff} + {{W{1'b0}}, subtract};
  assign sum      = full[W-1:0];

  // No carry out of A + ~B + 1 means a borrow, so A < B unsigned.
  assign lt_unsigned = ~full[W];
  // If the signs differ, A is the smaller one exactly when it is negative.
  // If they match, the sign of the difference decides.
  assign lt_signed   = (a[W-1] ^ b[W-1]) ? a[W-1] : full[W-1];
endmodule

// File: rtl/alu_shift_unit.sv
module alu_shift_unit
  import alu_pkg::*;
#(
  parameter int W  = 32,
  parameter int SW = $clog2(W)
) (
  input  shift_mode_e    mode,
  input  logic [SW-1:0]  amount,
  input  logic [W-1:0]   data,
  output logic [W-1:0]   y
);
  function automatic logic [W-1:0] bit_reverse(input logic [W-1:0] v);
    logic [W-1:0] r;
    for (int i = 0; i < W; i++) r[i] = v[W-1-i];
    return r;
  endfunction

  logic          fill;
  logic [W-1:0]  stage [0:SW];

  // Left shifts reuse the right-shift stages on the bit-reversed word.
  assign fill     = (mode == SH_RARI) & data[W-1];
  assign stage[0] = (mode == SH_LEFT) ? bit_reverse(data) : data;

  for (genvar s = 0; s < SW; s++) begin : g_stage
    localparam int STEP = 2 ** s;
    assign stage[s+1] = amount[s] ? {{STEP{fill}}, stage[s][W-1:STEP]} : stage[s];
  end

  assign y = (mode == SH_LEFT) ? bit_reverse(stage[SW]) : stage[SW];
endmodule

// File: rtl/alu_core.sv
module alu_core
  import alu_pkg::*;
#(
  parameter int W  = 32,
  parameter int SW = $clog2(W)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [3:0]    op_code,
  input  logic [W-1:0]  opnd_a,
  input  logic [W-1:0]  opnd_b,
  input  logic [SW-1:0] shamt,
  output logic [W-1:0]  result,
  output logic          zero
);
  alu_op_e       op;
  logic [W-1:0]  logic_y, sum_y, shift_y, res_next;
  logic          lt_s, lt_u;
  logic [SW-1:0] sh_amt;
  shift_mode_e   sh_mode;

  assign op = alu_op_e'(op_code);

  alu_logic_unit #(.W(W)) u_logic (
    .op(op), .a(opnd_a), .b(opnd_b), .y(logic_y)
  );

  alu_arith_unit #(.W(W)) u_arith (
    .op(op), .a(opnd_a), .b(opnd_b), .sum(sum_y),
    .lt_signed(lt_s), .lt_unsigned(lt_u)
  );

  // Codes 12 to 14 take the amount from operand A; the others use the instruction field.
  assign sh_amt = (op == OP_SLV || op == OP_SRV || op == OP_SAV) ? opnd_a[SW-1:0] : shamt;

  always_comb begin
    case (op)
      OP_SLI, OP_SLV: sh_mode = SH_LEFT;
      OP_SRI, OP_SRV: sh_mode = SH_RLOG;
      default:        sh_mode = SH_RARI;
    endcase
  end

  alu_shift_unit #(.W(W), .SW(SW)) u_shift (
    .mode(sh_mode), .amount(sh_amt), .data(opnd_b), .y(shift_y)
  );

  always_comb begin
    case (op)
      OP_AND, OP_OR, OP_XOR, OP_NOR, OP_UPH: res_next = logic_y;
      OP_ADD, OP_SUB:                        res_next = sum_y;
      OP_LTS:  res_next = {{(W-1){1'b0}}, lt_s};
      OP_LTU:  res_next = {{(W-1){1'b0}}, lt_u};
      OP_SLI, OP_SRI, OP_SAI,
      OP_SLV, OP_SRV, OP_SAV:                res_next = shift_y;
      default: res_next = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      result <= '0;
      zero   <= 1'b1;
    end else begin
      result <= res_next;
      zero   <= (res_next == '0);
    end
  end

  p_reset_clear_r11: assert property (@(posedge clk)
    rst |=> (result == '0 && zero));

  p_zero_flag_r10: assert property (@(posedge clk) disable iff (rst)
    zero == (result == '0));

  p_unused_zero_r9: assert property (@(posedge clk) disable iff (rst)
    (op_code == 4'd15) |=> (result == '0));

  // Covers R5 and also R6: a comparison sets bit 0 at most.
  p_cmp_bit0_r5: assert property (@(posedge clk) disable iff (rst)
    (op_code == 4'd7 || op_code == 4'd8) |=> (result[W-1:1] == '0));

  p_sub_self_r3: assert property (@(posedge clk) disable iff (rst)
    (op_code == 4'd5 && opnd_a == opnd_b) |=> zero);

  p_shift_noop_r13: assert property (@(posedge clk) disable iff (rst)
    (op_code == 4'd9 && shamt == '0) |=> (result == $past(opnd_b)));
endmodule

// File: tb/alu_core_test.sv
module alu_core_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [3:0]  op_code = '0;
  logic [31:0] opnd_a = '0, opnd_b = '0;
  logic [4:0]  shamt = '0;
  logic [31:0] result;
  logic        zero;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 0;

  alu_core uut (
    .clk(clk), .rst(rst), .op_code(op_code), .opnd_a(opnd_a),
    .opnd_b(opnd_b), .shamt(shamt), .result(result), .zero(zero)
  );

  always #4 clk = ~clk;

  function automatic logic [31:0] model(input logic [3:0] op, input logic [31:0] a,
                                        input logic [31:0] b, input logic [4:0] s);
    case (op)
      4'd0:  return a & b;
      4'd1:  return a | b;
      4'd2:  return a ^ b;
      4'd3:  return ~(a | b);
      4'd4:  return a + b;
      4'd5:  return a - b;
      4'd6:  return {b[15:0], 16'h0000};
      4'd7:  return ($signed(a) < $signed(b)) ? 32'd1 : 32'd0;
      4'd8:  return (a < b) ? 32'd1 : 32'd0;
      4'd9:  return b << s;
      4'd10: return b >> s;
      4'd11: return $unsigned($signed(b) >>> s);
      4'd12: return b << a[4:0];
      4'd13: return b >> a[4:0];
      4'd14: return $unsigned($signed(b) >>> a[4:0]);
      default: return 32'h0;
    endcase
  endfunction

  function automatic string tag_of(input logic [3:0] op);
    if (op <= 4'd3) return "R1";
    case (op)
      4'd4: return "R2";
      4'd5: return "R3";
      4'd6: return "R4";
      4'd7: return "R5";
      4'd8: return "R6";
      4'd9, 4'd10, 4'd11: return "R7";
      4'd12, 4'd13, 4'd14: return "R8";
      default: return "R9";
    endcase
  endfunction

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_checks++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h (op %0d a %h b %h s %0d)",
               tag, got, exp, op_code, opnd_a, opnd_b, shamt);
    end
  endtask

  // Inputs are applied 1 ns after an edge; outputs are compared 1 ns after the next edge.
  task automatic run(input logic [3:0] op, input logic [31:0] a, input logic [31:0] b,
                     input logic [4:0] s);
    logic [31:0] exp;
    op_code = op; opnd_a = a; opnd_b = b; shamt = s;
    exp = model(op, a, b, s);
    @(posedge clk); #1;
    check(tag_of(op), result, exp);
    check("R10", {31'b0, zero}, {31'b0, exp == 32'h0});
  endtask

  task automatic finish_up();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_checks++; n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_up();
  end

  logic [31:0] vals [7] = '{32'h0, 32'h1, 32'hFFFF_FFFF, 32'h8000_0000,
                            32'h7FFF_FFFF, 32'h1234_5678, 32'hDEAD_BEEF};
  logic [4:0]  amts [4] = '{5'd0, 5'd1, 5'd16, 5'd31};

  initial begin
    // R11: state held in reset
    repeat (3) @(posedge clk); #1;
    check("R11", result, 32'h0);
    check("R11", {31'b0, zero}, 32'd1);
    rst = 1'b0;

    // Sweep over every code with boundary operands and shift amounts
    for (int op = 0; op < 16; op++)
      for (int i = 0; i < 7; i++)
        for (int j = 0; j < 7; j++)
          for (int k = 0; k < 4; k++)
            run(op[3:0], vals[i], vals[j], amts[k]);

    // Random vectors
    for (int n = 0; n < 2000; n++)
      run(4'($urandom_range(0, 15)), $urandom, $urandom, 5'($urandom));

    // R13: shift corner values
    run(4'd11, 32'h0, 32'h8000_0000, 5'd31);
    check("R13", result, 32'hFFFF_FFFF);
    run(4'd14, 32'h0000_001F, 32'h9000_0001, 5'd0);
    check("R13", result, 32'hFFFF_FFFF);
    run(4'd13, 32'hFFFF_FFE0, 32'hCAFE_F00D, 5'd7);
    check("R13", result, 32'hCAFE_F00D);
    run(4'd9, 32'h0, 32'hA5A5_0F0F, 5'd0);
    check("R13", result, 32'hA5A5_0F0F);

    // R8: the instruction amount has no effect on the variable-amount codes
    run(4'd12, 32'h0000_0004, 32'h0000_0001, 5'd31);
    check("R8", result, 32'h0000_0010);

    // R12: no change before the edge
    run(4'd4, 32'd5, 32'd6, 5'd0);
    op_code = 4'd1; opnd_a = 32'hF000_0000; opnd_b = 32'h0;
    #2;
    check("R12", result, 32'd11);
    @(posedge clk); #1;
    check("R12", result, 32'hF000_0000);

    // R11: reset applied in the middle of a run
    rst = 1'b1;
    @(posedge clk); #1;
    check("R11", result, 32'h0);
    check("R11", {31'b0, zero}, 32'd1);
    rst = 1'b0;
    run(4'd3, 32'h0, 32'h0, 5'd0);

    finish_up();
  end
endmodule